// File: doc/BRIEF.md
# Pulse-Width Reset and Track Sequencer

This block serves a bank of sample-and-hold channels that share one active-low control line. The line does two jobs, and the block tells them apart by how long it stays low. Each low interval is measured in system clock cycles after a two-flop synchronizer. A short dip is treated as noise. A dip of medium length clears every channel back to its power-on condition. A low level that lasts past the upper threshold puts the channel that is currently selected into track mode, so that its output follows the live input.

The block also runs acquisitions. A channel, or all channels together for calibration, is selected with a one-cycle address strobe. If the control line is high at that moment, acquisition starts at once. If the line is low, the channel tracks until the line rises. While an acquisition runs, `busy_n` is low for a fixed number of cycles. When it ends, the channel's output select moves from the live input to the held value. During that time, pulses and address strobes have no effect. Analog switching appears only as one select bit per channel.

Top module: `trk_rst_seq`

## Requirements
- R1: After reset, `busy_n` is 1, `tracking` is 0, `rst_evt` is 0, every bit of `sel_hold` is 0, and the selected channel is 0.
- R2: A low interval on the synchronized control line shorter than RST_MIN cycles has no effect: no `rst_evt`, no change to `sel_hold` or `tracking`.
- R3: An idle low interval of RST_MIN to TRK_MIN cycles (both inclusive) raises `rst_evt` for exactly one cycle when the line returns high. In that same cycle `sel_hold` becomes all 0, and the selected channel returns to 0 with calibration off.
- R4: When an idle low interval reaches TRK_MIN+1 cycles, `tracking` rises, the selected channel's `sel_hold` bit (or every bit in calibration) goes to 0 (live input), and no `rst_evt` is produced.
- R5: While tracking, no acquisition begins: `busy_n` stays 1 until the synchronized line goes high. It then falls on the following cycle.
- R6: An address strobe taken while idle selects `addr_ch` (or all channels when `addr_all` = 1) and clears the selected `sel_hold` bits. If the line is high, `busy_n` is 0 from the next cycle. If the line is low, `tracking` is 1 from the next cycle, and the line's later rise does not count as a reset pulse.
- R7: `busy_n` stays low for exactly ACQ_CYC cycles for a single channel, or CAL_CYC cycles for all channels. `sel_hold` does not change while it is low. In the cycle `busy_n` returns high, the selected bits of `sel_hold` become 1 (held value).
- R8: While `busy_n` is low, address strobes and control pulses are ignored. A low interval still in progress when `busy_n` returns high is not measured: measuring resumes only after the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_n | input | 1 | Asynchronous active-low reset/track control line |
| addr_vld | input | 1 | One-cycle strobe that selects a channel |
| addr_ch | input | CHW | Channel number taken with the strobe |
| addr_all | input | 1 | With the strobe, selects all channels (calibration timing) |
| busy_n | output | 1 | Low while an acquisition runs |
| tracking | output | 1 | High while the selected channel waits in track mode |
| rst_evt | output | 1 | One-cycle pulse when a reset-width pulse clears the channels |
| sel_hold | output | NCH | Per channel: 1 = held value drives the output, 0 = live input |

## Verification
On every cycle, the checker confirms these properties: a reset event lasts one cycle and leaves all selects cleared; no reset event coincides with busy or tracking; the selects are frozen while busy is low; and at least one held select appears when busy ends. Only the directed scenarios can show the width classification. This means the exact boundaries at RST_MIN-1, RST_MIN, TRK_MIN and TRK_MIN+1. The scenarios also cover the exact busy lengths for single and calibration acquisitions, the choice between immediate start and tracking at address time, and the rejection of a low interval that straddles the end of an acquisition.

// File: rtl/trk_rst_seq.sv
module trk_rst_seq #(
  parameter int NCH     = 32,
  parameter int RST_MIN = 23,
  parameter int TRK_MIN = 50,
  parameter int ACQ_CYC = 4000,
  parameter int CAL_CYC = 11250,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW     = $clog2(TRK_MIN + 1),
  localparam int TMAX   = (ACQ_CYC > CAL_CYC) ? ACQ_CYC : CAL_CYC,
  localparam int TW     = $clog2(TMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_n,
  input  logic           addr_vld,
  input  logic [CHW-1:0] addr_ch,
  input  logic           addr_all,
  output logic           busy_n,
  output logic           tracking,
  output logic           rst_evt,
  output logic [NCH-1:0] sel_hold
);

  typedef enum logic [1:0] {S_IDLE, S_TRACK, S_ACQ} st_t;

  st_t            st;
  logic [1:0]     sync;
  logic           ctl_s, armed, cur_all;
  logic [CW-1:0]  lo_cnt;
  logic [CHW-1:0] cur_ch;
  logic [TW-1:0]  timer;
  logic [NCH-1:0] cur_mask, new_mask;
  logic           idle_meas, rst_hit, trk_hit;

  assign ctl_s     = sync[1];
  assign busy_n    = (st != S_ACQ);
  assign tracking  = (st == S_TRACK);
  assign cur_mask  = cur_all  ? {NCH{1'b1}} : (NCH'(1) << cur_ch);
  assign new_mask  = addr_all ? {NCH{1'b1}} : (NCH'(1) << addr_ch);
  assign idle_meas = (st == S_IDLE) && armed;
  assign rst_hit   = idle_meas && ctl_s && (lo_cnt >= CW'(RST_MIN));
  assign trk_hit   = idle_meas && !ctl_s && (lo_cnt == CW'(TRK_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], ctl_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      armed    <= 1'b1;
      lo_cnt   <= '0;
      cur_ch   <= '0;
      cur_all  <= 1'b0;
      timer    <= '0;
      sel_hold <= '0;
      rst_evt  <= 1'b0;
    end else begin
      rst_evt <= 1'b0;
      armed   <= (st == S_ACQ) ? 1'b0 : (armed | ctl_s);
      if (idle_meas && !ctl_s)
        lo_cnt <= (lo_cnt == CW'(TRK_MIN)) ? lo_cnt : lo_cnt + 1'b1;
      else
        lo_cnt <= '0;

      case (st)
        S_IDLE: begin
          if (rst_hit) begin
            rst_evt  <= 1'b1;
            sel_hold <= '0;
            cur_ch   <= '0;
            cur_all  <= 1'b0;
          end else if (trk_hit) begin
            st       <= S_TRACK;
            sel_hold <= sel_hold & ~cur_mask;
          end else if (addr_vld) begin
            cur_ch   <= addr_ch;
            cur_all  <= addr_all;
            sel_hold <= sel_hold & ~new_mask;
            if (ctl_s) begin
              st    <= S_ACQ;
              timer <= addr_all ? TW'(CAL_CYC - 1) : TW'(ACQ_CYC - 1);
            end else begin
              st <= S_TRACK;
            end
          end
        end
        S_TRACK: begin
          if (ctl_s) begin
            st    <= S_ACQ;
            timer <= cur_all ? TW'(CAL_CYC - 1) : TW'(ACQ_CYC - 1);
          end
        end
        S_ACQ: begin
          if (timer == '0) begin
            st       <= S_IDLE;
            sel_hold <= sel_hold | cur_mask;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trk_rst_seq_chk.sv
module trk_rst_seq_chk #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy_n,
  input logic           tracking,
  input logic           rst_evt,
  input logic [NCH-1:0] sel_hold
);

  p_evt_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> !rst_evt);

  p_evt_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |-> (sel_hold == '0));

  p_no_evt_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !rst_evt);

  p_no_evt_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tracking |-> !rst_evt);

  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> (busy_n || $stable(sel_hold)));

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (sel_hold != '0));

endmodule

bind trk_rst_seq trk_rst_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .tracking(tracking),
  .rst_evt(rst_evt), .sel_hold(sel_hold)
);

// File: tb/tb_trk_rst_seq.sv
module tb_trk_rst_seq;
  localparam int NCH = 8, RMIN = 6, TMIN = 12, ACQ = 20, CAL = 40;
  localparam int CHW = 3;

  logic clk = 0, rst_n = 0, ctl_n = 1, addr_vld = 0, addr_all = 0;
  logic [CHW-1:0] addr_ch = '0;
  logic busy_n, tracking, rst_evt;
  logic [NCH-1:0] sel_hold;
  int n_chk = 0, n_bad = 0, rst_cnt = 0, run = 0, last_busy = 0;

  trk_rst_seq #(.NCH(NCH), .RST_MIN(RMIN), .TRK_MIN(TMIN), .ACQ_CYC(ACQ), .CAL_CYC(CAL)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .addr_vld(addr_vld), .addr_ch(addr_ch),
    .addr_all(addr_all), .busy_n(busy_n), .tracking(tracking), .rst_evt(rst_evt),
    .sel_hold(sel_hold));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_evt) rst_cnt++;
    if (!busy_n) run++;
    else if (run != 0) begin last_busy = run; run = 0; end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w);
    ctl_n = 0; waitn(w); ctl_n = 1;
  endtask

  task automatic strobe(input int ch, input bit all);
    addr_ch = CHW'(ch); addr_all = all; addr_vld = 1;
    waitn(1); addr_vld = 0; addr_all = 0;
  endtask

  task automatic t_reset_state;
    chk("R1 busy_n", busy_n, 1);
    chk("R1 tracking", tracking, 0);
    chk("R1 rst_evt", rst_evt, 0);
    chk("R1 sel_hold", sel_hold, 0);
  endtask

  task automatic t_addr_high;
    strobe(3, 0);
    chk("R6 busy next cycle", busy_n, 0);
    chk("R7 hold frozen", sel_hold, 0);
    waitn(25);
    chk("R7 busy length", last_busy, ACQ);
    chk("R7 hold set", sel_hold, 8'h08);
  endtask

  task automatic t_glitch;
    int r0 = rst_cnt;
    pulse(RMIN - 1); waitn(8);
    chk("R2 no reset", rst_cnt - r0, 0);
    chk("R2 hold kept", sel_hold, 8'h08);
    chk("R2 no track", tracking, 0);
  endtask

  task automatic t_reset_pulse;
    int r0 = rst_cnt;
    pulse(RMIN); waitn(8);
    chk("R3 reset at min", rst_cnt - r0, 1);
    chk("R3 cleared", sel_hold, 0);
    strobe(5, 0); waitn(25);
    chk("R7 ch5 held", sel_hold, 8'h20);
    pulse(TMIN); waitn(8);
    chk("R3 reset at max", rst_cnt - r0, 2);
    chk("R3 cleared max", sel_hold, 0);
    chk("R4 no track at max", tracking, 0);
  endtask

  task automatic t_track;
    int r0 = rst_cnt;
    strobe(4, 0); waitn(25);
    pulse(8); waitn(6);
    chk("R3 ch4 cleared", sel_hold, 0);
    ctl_n = 0; waitn(TMIN + 4);
    chk("R4 tracking", tracking, 1);
    chk("R5 no acq while low", busy_n, 1);
    ctl_n = 1; waitn(4);
    chk("R5 acq after rise", busy_n, 0);
    waitn(25);
    chk("R3 channel back to 0", sel_hold, 8'h01);
    chk("R4 no extra reset", rst_cnt - r0, 1);
    chk("R7 busy length track", last_busy, ACQ);
  endtask

  task automatic t_addr_low;
    int r0 = rst_cnt;
    ctl_n = 0; waitn(3);
    strobe(0, 0);
    chk("R6 tracking on low", tracking, 1);
    chk("R6 live select", sel_hold, 0);
    waitn(4); ctl_n = 1; waitn(30);
    chk("R6 rise not reset", rst_cnt - r0, 0);
    chk("R6 held after", sel_hold, 8'h01);
    chk("R7 busy length", last_busy, ACQ);
  endtask

  task automatic t_cal;
    strobe(0, 1);
    waitn(CAL + 5);
    chk("R7 cal length", last_busy, CAL);
    chk("R7 cal all held", sel_hold, 8'hFF);
  endtask

  task automatic t_busy_ignore;
    int r0 = rst_cnt;
    strobe(1, 0); waitn(3);
    strobe(2, 0); waitn(2);
    pulse(8); waitn(1);
    ctl_n = 0; waitn(15); ctl_n = 1; waitn(10);
    chk("R8 no reset", rst_cnt - r0, 0);
    chk("R8 busy not restarted", last_busy, ACQ);
    chk("R8 holds kept", sel_hold, 8'hFF);
    chk("R8 no track", tracking, 0);
  endtask

  initial begin
    waitn(3); rst_n = 1; waitn(2);
    t_reset_state();
    t_addr_high();
    t_glitch();
    t_reset_pulse();
    t_track();
    t_addr_low();
    t_cal();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule